// File: doc/BRIEF.md
# Reference Failure Mode Controller

This block chooses the operating mode of a telecom timing PLL core. It watches a two-bit mode request, already-decoded OK flags for a primary and a secondary reference, a reference-select bit and a one-millisecond tick. From these it drives a two-bit mode code, a one-cycle lock-enable pulse for the loop, and a seven-bit status word.

The states are Normal, Auto-Holdover, Holdover and Free-run. When the active reference fails while Normal is requested, the core drops into Auto-Holdover on its own. The reference must then stay OK for a fixed number of millisecond ticks before the core relocks. That wait is 35 by default, and it starts again from zero whenever the reference drops. Forced Holdover and Free-run requests take effect from any state. A Normal request while neither reference is OK is refused and flagged.

Named transitions:
- Free-run or Holdover to Auto-Holdover: entry qualification.
- Normal to Auto-Holdover: reference failure.
- Auto-Holdover to Normal: requalified.
- Any state to Holdover: forced holdover.
- Any state to Free-run: forced free-run.
- Request refused: stay in Free-run or Holdover.
- Reserved request: freeze.

Top module: `ref_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the state is Free-run. The mode output is 11, lock_en is 0, and the status word reads 0x03 (cause none, no reject) as long as no reference is OK.
- R2: The mode output codes are 00 Normal, 01 Auto-Holdover, 10 Holdover and 11 Free-run. The request codes on mode_sel are 00 Normal, 01 forced Holdover and 10 forced Free-run. A forced Holdover or Free-run request is taken from any state and shows on the mode output one clock after it is sampled.
- R3: ref_sel = 0 makes the primary reference the active one, and ref_sel = 1 makes the secondary the active one. A failure of the reference that is not active has no effect on the mode.
- R4: In Normal with request 00, a low OK flag on the active reference moves the state to Auto-Holdover on the next clock, with cause code 01.
- R5: The qualification count advances on each ms_tick while the active reference is OK, and it clears in any cycle where that reference is not OK. Auto-Holdover goes to Normal on the clock after the count reaches QUAL_TICKS (35).
- R6: lock_en is high for exactly one cycle, which is the first cycle of Normal reached from Auto-Holdover. It is never high at any other time.
- R7: A Normal request in Free-run or Holdover while both references are not OK is refused. The state stays where it is and the reject bit is 1 on the next clock. If at least one reference is OK, the state goes to Auto-Holdover with cause code 10.
- R8: Request code 11 freezes the state, even when references fail or recover.
- R9: The status word is laid out as follows:
  - [1:0] the mode code.
  - [3:2] the cause: 00 none (Normal, Free-run), 01 reference failure, 10 entry qualification, 11 forced holdover.
  - [4] reject.
  - [5] active reference OK.
  - [6] qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode request: 00 Normal, 01 Holdover, 10 Free-run, 11 no change |
| ref_sel | input | 1 | Active reference: 0 primary, 1 secondary |
| pri_ok | input | 1 | Primary reference usable (not lost, within frequency limit) |
| sec_ok | input | 1 | Secondary reference usable |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| mode | output | 2 | Current mode code |
| lock_en | output | 1 | One-cycle pulse on entry into Normal |
| status | output | 7 | Mode, holdover cause, reject, active OK, qualified |

## Verification
A change of request or reference flag appears on mode and status one clock after it is sampled. The qualification count sees a tick one clock after it arrives. Normal and lock_en therefore appear one clock after the tick that completes the count. The bench drives inputs on the falling edge and samples on a later falling edge. After the 34th tick it expects Auto-Holdover, and after the 35th it expects Normal with the pulse. A restart test drops the reference partway through the count and requires the full count again.

// File: rtl/ref_mode_pkg.sv
package ref_mode_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL    = 2'b00,
        ST_AUTO_HOLD = 2'b01,
        ST_HOLDOVER  = 2'b10,
        ST_FREERUN   = 2'b11
    } ctrl_state_t;

    typedef enum logic [1:0] {
        REQ_NORMAL = 2'b00,
        REQ_HOLD   = 2'b01,
        REQ_FREE   = 2'b10,
        REQ_KEEP   = 2'b11
    } mode_req_t;

    typedef enum logic [1:0] {
        CAUSE_NONE       = 2'b00,
        CAUSE_REF_FAIL   = 2'b01,
        CAUSE_ENTRY_QUAL = 2'b10,
        CAUSE_FORCED     = 2'b11
    } hold_cause_t;

    localparam int STATUS_W = 7;

endpackage

// File: rtl/ref_select_qual.sv
module ref_select_qual #(
    parameter int QUAL_TICKS = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_sel,
    input  logic pri_ok,
    input  logic sec_ok,
    input  logic ms_tick,
    output logic active_ok,
    output logic any_ok,
    output logic qualified
);
    localparam int CNT_W = $clog2(QUAL_TICKS + 1);
    localparam logic [CNT_W-1:0] QUAL_MAX = CNT_W'(QUAL_TICKS);

    logic [CNT_W-1:0] qual_cnt;

    assign active_ok = ref_sel ? sec_ok : pri_ok;
    assign any_ok    = pri_ok | sec_ok;

    // R5: count ticks while the active reference holds, restart on any drop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_cnt <= '0;
        end else if (!active_ok) begin
            qual_cnt <= '0;
        end else if (ms_tick && qual_cnt != QUAL_MAX) begin
            qual_cnt <= qual_cnt + 1'b1;
        end
    end

    assign qualified = active_ok && (qual_cnt == QUAL_MAX);

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import ref_mode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_sel,
    input  logic        active_ok,
    input  logic        any_ok,
    input  logic        qualified,
    output ctrl_state_t state,
    output hold_cause_t cause,
    output logic        reject,
    output logic        lock_en
);
    mode_req_t   req;
    ctrl_state_t nxt_state;
    hold_cause_t nxt_cause;
    logic        nxt_reject;

    assign req = mode_req_t'(mode_sel);

    always_comb begin
        nxt_state = state;
        nxt_cause = cause;
        unique case (req)
            REQ_HOLD: begin
                nxt_state = ST_HOLDOVER;
                nxt_cause = CAUSE_FORCED;
            end
            REQ_FREE: begin
                nxt_state = ST_FREERUN;
                nxt_cause = CAUSE_NONE;
            end
            REQ_KEEP: begin
                nxt_state = state;
            end
            REQ_NORMAL: begin
                unique case (state)
                    ST_NORMAL: begin
                        if (!active_ok) begin
                            nxt_state = ST_AUTO_HOLD;
                            nxt_cause = CAUSE_REF_FAIL;
                        end
                    end
                    ST_AUTO_HOLD: begin
                        if (qualified) begin
                            nxt_state = ST_NORMAL;
                            nxt_cause = CAUSE_NONE;
                        end
                    end
                    ST_HOLDOVER, ST_FREERUN: begin
                        if (any_ok) begin
                            nxt_state = ST_AUTO_HOLD;
                            nxt_cause = CAUSE_ENTRY_QUAL;
                        end
                    end
                endcase
            end
        endcase
    end

    assign nxt_reject = (req == REQ_NORMAL) && !any_ok &&
                        (state == ST_HOLDOVER || state == ST_FREERUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FREERUN;
            cause <= CAUSE_NONE;
        end else begin
            state <= nxt_state;
            cause <= nxt_cause;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_en <= 1'b0;
            reject  <= 1'b0;
        end else begin
            lock_en <= (state == ST_AUTO_HOLD) && (nxt_state == ST_NORMAL);
            reject  <= nxt_reject;
        end
    end

endmodule

// File: rtl/status_pack.sv
module status_pack
    import ref_mode_pkg::*;
(
    input  ctrl_state_t          state,
    input  hold_cause_t          cause,
    input  logic                 reject,
    input  logic                 active_ok,
    input  logic                 qualified,
    output logic [STATUS_W-1:0]  status
);
    assign status = {qualified, active_ok, reject, cause, state};
endmodule

// File: rtl/ref_mode_ctrl.sv
module ref_mode_ctrl
    import ref_mode_pkg::*;
#(
    parameter int QUAL_TICKS = 35
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_sel,
    input  logic                ref_sel,
    input  logic                pri_ok,
    input  logic                sec_ok,
    input  logic                ms_tick,
    output logic [1:0]          mode,
    output logic                lock_en,
    output logic [STATUS_W-1:0] status
);
    logic        active_ok;
    logic        any_ok;
    logic        qualified;
    ctrl_state_t state;
    hold_cause_t cause;
    logic        reject;

    ref_select_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_sel   (ref_sel),
        .pri_ok    (pri_ok),
        .sec_ok    (sec_ok),
        .ms_tick   (ms_tick),
        .active_ok (active_ok),
        .any_ok    (any_ok),
        .qualified (qualified)
    );

    mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .active_ok (active_ok),
        .any_ok    (any_ok),
        .qualified (qualified),
        .state     (state),
        .cause     (cause),
        .reject    (reject),
        .lock_en   (lock_en)
    );

    status_pack u_stat (
        .state     (state),
        .cause     (cause),
        .reject    (reject),
        .active_ok (active_ok),
        .qualified (qualified),
        .status    (status)
    );

    assign mode = state;

endmodule

// File: rtl/ref_mode_ctrl_chk.sv
module ref_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       ref_sel,
    input logic       pri_ok,
    input logic       sec_ok,
    input logic [1:0] mode,
    input logic       lock_en,
    input logic [6:0] status
);
    logic act_ok;
    assign act_ok = ref_sel ? sec_ok : pri_ok;

    a_r6_pulse_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        lock_en |-> (mode == 2'b00 && $past(mode) == 2'b01));

    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        lock_en |=> !lock_en);

    a_r4_fail_leaves_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && mode_sel == 2'b00 && !act_ok) |=> (mode == 2'b01 && status[3:2] == 2'b01));

    a_r7_refuse_without_ref: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b10 || mode == 2'b11) && mode_sel == 2'b00 && !pri_ok && !sec_ok)
        |=> ($stable(mode) && status[4]));

    a_r8_reserved_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |=> $stable(mode));

    a_r5_normal_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && $past(mode) == 2'b01) |-> $past(status[6]));

    a_r2_forced_holdover: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01) |=> (mode == 2'b10 && status[3:2] == 2'b11));

endmodule

bind ref_mode_ctrl ref_mode_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .ref_sel  (ref_sel),
    .pri_ok   (pri_ok),
    .sec_ok   (sec_ok),
    .mode     (mode),
    .lock_en  (lock_en),
    .status   (status)
);

// File: tb/ref_mode_ctrl_tb.sv
module ref_mode_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       ref_sel = 1'b0;
    logic       pri_ok = 1'b0;
    logic       sec_ok = 1'b0;
    logic       ms_tick = 1'b0;
    logic [1:0] mode;
    logic       lock_en;
    logic [6:0] status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ref_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_sel(ref_sel),
        .pri_ok(pri_ok), .sec_ok(sec_ok), .ms_tick(ms_tick),
        .mode(mode), .lock_en(lock_en), .status(status)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        cyc(2);
        chk("R1 mode in reset", {6'd0, mode}, 8'h03);
        chk("R1 lock_en in reset", {7'd0, lock_en}, 8'h00);
        chk("R1 R9 status in reset", {1'b0, status}, 8'h03);
        rst_n = 1'b1;
    endtask

    task automatic t_reject;
        cyc(1);
        chk("R7 refused from free-run", {6'd0, mode}, 8'h03);
        chk("R7 R9 reject bit", {1'b0, status}, 8'h13);
        tick(3);
        chk("R7 still free-run without refs", {6'd0, mode}, 8'h03);
    endtask

    task automatic t_startup;
        pri_ok = 1'b1;
        cyc(1);
        chk("R7 R9 entry qualification status", {1'b0, status}, 8'h29);
        tick(34);
        chk("R5 not yet qualified at 34", {6'd0, mode}, 8'h01);
        chk("R6 no pulse while waiting", {7'd0, lock_en}, 8'h00);
        tick(1);
        chk("R5 normal after 35 ticks", {6'd0, mode}, 8'h00);
        chk("R6 lock pulse on entry", {7'd0, lock_en}, 8'h01);
        cyc(1);
        chk("R6 pulse lasts one cycle", {7'd0, lock_en}, 8'h00);
        chk("R9 normal status", {1'b0, status}, 8'h60);
    endtask

    task automatic t_fail_restart;
        pri_ok = 1'b0;
        cyc(1);
        chk("R4 R9 auto-holdover on failure", {1'b0, status}, 8'h05);
        pri_ok = 1'b1;
        tick(20);
        pri_ok = 1'b0;
        cyc(1);
        pri_ok = 1'b1;
        tick(34);
        chk("R5 restart needs full count", {6'd0, mode}, 8'h01);
        tick(1);
        chk("R5 normal after restarted count", {6'd0, mode}, 8'h00);
        chk("R6 pulse after restart", {7'd0, lock_en}, 8'h01);
    endtask

    task automatic t_secondary;
        sec_ok = 1'b1;
        ref_sel = 1'b1;
        cyc(1);
        pri_ok = 1'b0;
        cyc(2);
        chk("R3 inactive primary ignored", {6'd0, mode}, 8'h00);
        chk("R3 no pulse", {7'd0, lock_en}, 8'h00);
        sec_ok = 1'b0;
        cyc(1);
        chk("R3 R4 secondary failure", {6'd0, mode}, 8'h01);
        sec_ok = 1'b1;
        tick(35);
        chk("R3 R5 relock on secondary", {6'd0, mode}, 8'h00);
        pri_ok = 1'b1;
        ref_sel = 1'b0;
        cyc(1);
    endtask

    task automatic t_forced;
        mode_sel = 2'b01;
        cyc(1);
        chk("R2 R9 forced holdover", {1'b0, status}, 8'h6E);
        mode_sel = 2'b10;
        cyc(1);
        chk("R2 R9 forced free-run", {1'b0, status}, 8'h63);
    endtask

    task automatic t_reserved;
        mode_sel = 2'b01;
        cyc(1);
        mode_sel = 2'b11;
        pri_ok = 1'b0;
        sec_ok = 1'b0;
        cyc(3);
        chk("R8 reserved code freezes", {6'd0, mode}, 8'h02);
        mode_sel = 2'b00;
        cyc(1);
        chk("R7 refused from holdover", {6'd0, mode}, 8'h02);
        chk("R7 reject from holdover", {7'd0, status[4]}, 8'h01);
    endtask

    task automatic t_return;
        pri_ok = 1'b1;
        sec_ok = 1'b1;
        cyc(1);
        chk("R7 holdover to auto-holdover", {4'd0, status[3:2], mode}, 8'h09);
        tick(35);
        chk("R5 relock from holdover", {6'd0, mode}, 8'h00);
        chk("R6 pulse from holdover path", {7'd0, lock_en}, 8'h01);
        mode_sel = 2'b01;
        cyc(1);
        mode_sel = 2'b00;
        cyc(1);
        chk("R7 quick return via auto-holdover", {6'd0, mode}, 8'h01);
        cyc(1);
        chk("R5 already qualified relocks", {6'd0, mode}, 8'h00);
        chk("R6 pulse on quick return", {7'd0, lock_en}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_reject();
        t_startup();
        t_fail_restart();
        t_secondary();
        t_forced();
        t_reserved();
        t_return();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule